// File: doc/BRIEF.md
# Fractional Clock-Enable Divider (N of 32)

This block turns a free-running input clock into a clock-enable strobe. A fixed integer pre-divider first produces one tick every `PREDIV` input cycles. A phase accumulator then lets through exactly N of every 32 ticks, with the pulses spread as evenly as possible. The output rate is therefore `f_in * N / (32 * PREDIV)`, where N runs from 1 to 32. Downstream logic uses the strobe to qualify its own flops. No gated clock is produced.

Software sets N through a 5-bit field that holds `32 - N`. A field value of 0 therefore means full rate and 31 means one pulse in 32. The field sits at a bit offset fixed per instance (`FIELD_OFS`, 0 to 95). That offset places it in one of three 32-bit registers: control A (offsets 0-31), control B (32-63) or the kick register (64-95). The field must fit inside its register and must not reach bit 31 of the kick register. A new field value has no effect until software sets the shared kick bit, which is bit 31 of the kick register. The bit then reads back as 1 until the divider adopts the new ratio at the next 32-tick window boundary. At that boundary the bit clears by itself, so a window is never split between two ratios.

Top module: `nswal_top`

## Requirements
- R1: After reset, all three registers read 0, the kick bit is clear, `clk_en` is low, and the divider runs at full rate (32 pulses per window).
- R2: Once a kicked ratio is active, every span of `32*PREDIV` consecutive input cycles holds exactly `32 - F` enable pulses, where F is the committed field value. This holds for every F from 0 to 31.
- R3: The ratio is taken only from bits `[FIELD_OFS+4:FIELD_OFS]` of the concatenation {kick, control B, control A}. Control A and control B read back what was last written to them, and bits outside the field do not affect the ratio.
- R4: Writing a new field value without a kick leaves the pulse count unchanged.
- R5: Writing 1 to bit 31 of the kick register makes that bit read 1 on the next cycle. The bit returns to 0 by itself within `32*PREDIV` cycles.
- R6: The active multiplier changes only on a window boundary while a kick is pending, the kick bit falls on that same edge, and the multiplier always stays within 1 to 32.
- R7: Pulse spacing is even. Every gap between consecutive enable pulses is between `PREDIV*floor(32/N)` and `PREDIV*ceil(32/N)` cycles.
- R8: `clk_en` is asserted only in the cycle after a pre-divided tick. At full rate it pulses exactly once every `PREDIV` cycles.
- R9: A kick-register write with bit 31 = 0 stores bits 30:0 and starts no update. A write with select code 3 changes nothing. Select codes are 0 for control A, 1 for control B and 2 for kick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control A, 1 control B, 2 kick, 3 none |
| wr_data | input | 32 | Write data |
| clk_en | output | 1 | Clock-enable strobe, N pulses per 32 ticks |
| ctrl_a_q | output | 32 | Control A register contents |
| ctrl_b_q | output | 32 | Control B register contents |
| kick_q | output | 32 | Kick register contents, bit 31 = update pending |

## Verification
The pulse counter is tried with every field value from 0 to 31. Each value gives a distinct pulse count per window, so a wrong inversion, an off-by-one in the accumulator or a lost carry shows up as a count mismatch. The spacing check tells an evenly spread accumulator apart from a burst-then-idle swallower. Directed writes cover the remaining cases: a field change without a kick, a kick-register write with the kick bit low, a write to the unused select, and noise in the neighbouring register. These separate a divider that follows the raw field from one that waits for a committed kick.

// File: rtl/nswal_pkg.sv
package nswal_pkg;

    localparam int REG_W   = 32;
    localparam int FIELD_W = 5;
    localparam int WIN     = 32;
    localparam int MULT_W  = 6;
    localparam int KICK_BIT = 31;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [MULT_W-1:0]  mult_t;
    typedef logic [REG_W-1:0]   word_t;

    typedef enum logic [1:0] {
        SEL_CTRL_A = 2'd0,
        SEL_CTRL_B = 2'd1,
        SEL_KICK   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     we;
        reg_sel_e sel;
        word_t    data;
    } wr_req_t;

    typedef struct packed {
        logic [FIELD_W-1:0] slot;
        logic [MULT_W-1:0]  acc;
    } phase_t;

    // Stored value is the complement of the multiplier against a full window.
    function automatic mult_t field_to_mult(field_t f);
        return mult_t'(WIN) - mult_t'(f);
    endfunction

    // Field must lie inside one register and stay clear of the kick flag.
    function automatic bit ofs_legal(int ofs);
        int bank;
        int loc;
        if (ofs < 0 || ofs > 95) return 1'b0;
        bank = ofs / REG_W;
        loc  = ofs % REG_W;
        if (bank == 2) return (loc + FIELD_W - 1) < KICK_BIT;
        return (loc + FIELD_W - 1) < REG_W;
    endfunction

endpackage

// File: rtl/nswal_regs.sv
module nswal_regs
    import nswal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              req,
    input  logic                 kick_done,
    output logic [1:0][REG_W-1:0] ctrl_q,
    output word_t                kick_q
);

    for (genvar b = 0; b < 2; b++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[b] <= '0;
            end else if (req.we && req.sel == reg_sel_e'(b)) begin
                ctrl_q[b] <= req.data;
            end
        end
    end

    logic kick_wr;
    assign kick_wr = req.we && (req.sel == SEL_KICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            kick_q <= '0;
        end else begin
            if (kick_wr) begin
                kick_q[KICK_BIT-1:0] <= req.data[KICK_BIT-1:0];
            end
            // a fresh request wins over the completion of the previous one
            if (kick_wr && req.data[KICK_BIT]) begin
                kick_q[KICK_BIT] <= 1'b1;
            end else if (kick_done) begin
                kick_q[KICK_BIT] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nswal_commit.sv
module nswal_commit
    import nswal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pend,
    input  logic   win_end,
    input  field_t field,
    output mult_t  act_mult,
    output logic   kick_done
);

    assign kick_done = win_end && pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mult <= mult_t'(WIN);
        end else if (kick_done) begin
            act_mult <= field_to_mult(field);
        end
    end

endmodule

// File: rtl/nswal_engine.sv
module nswal_engine
    import nswal_pkg::*;
#(
    parameter int PREDIV = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  mult_t mult,
    output logic  tick,
    output logic  win_end,
    output logic  clk_en
);

    localparam int PD_W = (PREDIV > 1) ? $clog2(PREDIV) : 1;

    if (PREDIV == 1) begin : g_nodiv
        assign tick = 1'b1;
    end else begin : g_div
        logic [PD_W-1:0] pd_q;
        always_ff @(posedge clk) begin
            if (rst)                             pd_q <= '0;
            else if (pd_q == PD_W'(PREDIV - 1))  pd_q <= '0;
            else                                 pd_q <= pd_q + 1'b1;
        end
        assign tick = (pd_q == PD_W'(PREDIV - 1));
    end

    phase_t ph_q;
    mult_t  sum;

    // acc stays below WIN and mult is at most WIN, so bit 5 is the carry
    assign sum     = ph_q.acc + mult;
    assign win_end = tick && (ph_q.slot == FIELD_W'(WIN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            clk_en <= 1'b0;
        end else begin
            clk_en <= tick && sum[MULT_W-1];
            if (tick) begin
                ph_q.slot <= ph_q.slot + 1'b1;
                ph_q.acc  <= {1'b0, sum[MULT_W-2:0]};
            end
        end
    end

endmodule

// File: rtl/nswal_top.sv
module nswal_top
    import nswal_pkg::*;
#(
    parameter int FIELD_OFS = 40,
    parameter int PREDIV    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        clk_en,
    output logic [31:0] ctrl_a_q,
    output logic [31:0] ctrl_b_q,
    output logic [31:0] kick_q
);

    if (!ofs_legal(FIELD_OFS)) begin : g_bad_ofs
        $error("nswal_top: FIELD_OFS out of range");
    end

    wr_req_t              req;
    logic [1:0][REG_W-1:0] ctrl_q;
    logic [3*REG_W-1:0]   all_regs;
    field_t               field;
    mult_t                act_mult;
    logic                 kick_done;
    logic                 kick_pend;
    logic                 tick;
    logic                 win_end;

    assign req = '{we: wr_en, sel: reg_sel_e'(wr_sel), data: wr_data};

    nswal_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .kick_done (kick_done),
        .ctrl_q    (ctrl_q),
        .kick_q    (kick_q)
    );

    assign ctrl_a_q  = ctrl_q[0];
    assign ctrl_b_q  = ctrl_q[1];
    assign kick_pend = kick_q[KICK_BIT];
    assign all_regs  = {kick_q, ctrl_q[1], ctrl_q[0]};
    assign field     = all_regs[FIELD_OFS +: FIELD_W];

    nswal_commit u_commit (
        .clk       (clk),
        .rst       (rst),
        .pend      (kick_pend),
        .win_end   (win_end),
        .field     (field),
        .act_mult  (act_mult),
        .kick_done (kick_done)
    );

    nswal_engine #(.PREDIV(PREDIV)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .mult    (act_mult),
        .tick    (tick),
        .win_end (win_end),
        .clk_en  (clk_en)
    );

endmodule

// File: rtl/nswal_chk.sv
module nswal_chk (
    input logic       clk,
    input logic       rst,
    input logic       clk_en,
    input logic       kick_pend,
    input logic       win_end,
    input logic       tick,
    input logic [5:0] act_mult
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!kick_pend && !clk_en && act_mult == 6'd32));

    // R6
    mult_range_chk: assert property (@(posedge clk) disable iff (rst)
        (act_mult >= 6'd1 && act_mult <= 6'd32));

    // R6
    mult_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_mult) |-> $past(win_end && kick_pend));

    // R6
    kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(kick_pend) |-> $past(win_end));

    // R8
    en_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> $past(tick));

endmodule

bind nswal_top nswal_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .kick_pend (kick_pend),
    .win_end   (win_end),
    .tick      (tick),
    .act_mult  (act_mult)
);

// File: tb/sim_nswal_top.sv
module sim_nswal_top;

    localparam int OFS  = 40;
    localparam int PD   = 3;
    localparam int WCYC = 32 * PD;
    localparam int LOC  = OFS % 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        clk_en;
    logic [31:0] ctrl_a_q, ctrl_b_q, kick_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    nswal_top #(.FIELD_OFS(OFS), .PREDIV(PD)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clk_en(clk_en), .ctrl_a_q(ctrl_a_q), .ctrl_b_q(ctrl_b_q), .kick_q(kick_q)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic kick();
        int n;
        wr(2'd2, 32'h8000_0000);
        chk(kick_q[31] == 1'b1, "R5 kick pending", kick_q[31], 1);
        n = 0;
        while (kick_q[31] && n <= WCYC + 4) begin
            @(negedge clk);
            n++;
        end
        chk(n <= WCYC, "R5 kick self-clear cycles", n, WCYC);
    endtask

    task automatic measure(output int c1, output int gmin, output int gmax);
        int last;
        c1 = 0; gmin = 1 << 30; gmax = 0; last = -1;
        repeat (2 * WCYC) @(negedge clk);
        for (int i = 0; i < 2 * WCYC; i++) begin
            @(negedge clk);
            if (clk_en) begin
                if (i < WCYC) c1++;
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
        end
        if (gmax == 0) begin gmin = WCYC; gmax = WCYC; end
    endtask

    task automatic expect_rate(input int m, input string tag);
        int c1, gmin, gmax;
        measure(c1, gmin, gmax);
        chk(c1 == m, tag, c1, m);
        chk(gmin >= PD * (32 / m), "R7 min gap", gmin, PD * (32 / m));
        chk(gmax <= PD * ((32 + m - 1) / m), "R7 max gap", gmax, PD * ((32 + m - 1) / m));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int c1, gmin, gmax;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ctrl_a_q == 0 && ctrl_b_q == 0 && kick_q == 0, "R1 registers zero",
            ctrl_a_q | ctrl_b_q | kick_q, 0);
        chk(clk_en == 1'b0, "R1 enable low in reset", clk_en, 0);
        rst = 1'b0;
        measure(c1, gmin, gmax);
        chk(c1 == 32, "R1 full rate after reset", c1, 32);
        // R8 full-rate spacing equals pre-divider
        chk(gmin == PD && gmax == PD, "R8 full-rate gap", gmax, PD);

        // field 5 -> multiplier 27
        wr(2'd1, 32'(5) << LOC);
        kick();
        expect_rate(27, "R2 field 5");

        // R4 new field without kick
        wr(2'd1, 32'(20) << LOC);
        chk(ctrl_b_q == (32'(20) << LOC), "R3 control B readback", ctrl_b_q, 32'(20) << LOC);
        expect_rate(27, "R4 no kick keeps ratio");

        // R9 kick register write with flag low
        wr(2'd2, 32'h0000_1234);
        chk(kick_q == 32'h0000_1234, "R9 kick reg low bits stored", kick_q, 32'h1234);
        expect_rate(27, "R9 flag-low write starts nothing");

        // R9 unused select
        wr(2'd3, 32'hFFFF_FFFF);
        chk(ctrl_a_q == 0 && ctrl_b_q == (32'(20) << LOC) && kick_q == 32'h0000_1234,
            "R9 select 3 ignored", ctrl_a_q, 0);

        // R3 neighbouring register noise is irrelevant
        wr(2'd0, 32'hFFFF_FFFF);
        chk(ctrl_a_q == 32'hFFFF_FFFF, "R3 control A readback", ctrl_a_q, 32'hFFFF_FFFF);
        kick();
        expect_rate(12, "R3 field 20 with noise in control A");

        // R2 sweep every field value
        for (int f = 0; f < 32; f++) begin
            wr(2'd1, (32'(f) << LOC) | 32'h8000_0001);
            kick();
            expect_rate(32 - f, $sformatf("R2 field %0d", f));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule